// File: doc/BRIEF.md
# Banked Maskable Interrupt Controller

This block gathers 96 level-sensitive interrupt lines, lets software mask each line on its own, and presents one interrupt request to the processor. The lines are grouped into three banks of 32. Each bank has a mask register that software can load in full. Each bank also has two single-purpose aliases: one sets selected mask bits, the other clears them. A driver can therefore enable or disable one line with a single write and no read-modify-write.

Every cycle, the unmasked pending lines are arbitrated, and the lowest-numbered line wins. When the controller is idle and a winner exists, its number is latched into a status register and the interrupt output goes high. The latched number and the output then stay frozen while the handler runs. Software ends the handshake by writing the agreement bit of the control word. The controller then drops the request and starts arbitration again on the next clock.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every mask bit is 1, `irq_out` is low, and the status word reads 0.
- R2: Word address 4*b holds the full mask of bank b (b = 0..2). A write loads all 32 bits, and a read returns the current mask. Writing all ones to every bank disables every line.
- R3: A write to word 4*b+1 sets the mask bits of bank b where the write data is 1. Mask bits where the data is 0 keep their value.
- R4: A write to word 4*b+2 clears the mask bits of bank b where the write data is 1. Mask bits where the data is 0 keep their value.
- R5: Line n is controlled by bit n mod 32 of bank n/32. While that bit is 1, the line can never raise `irq_out`.
- R6: When several unmasked lines are pending, the line with the lowest number is the one latched.
- R7: The status word is at address 12. Bits 6:0 hold the latched line number, and bit 7 is the valid flag. When the controller is idle and an unmasked line is pending at a clock edge, that edge latches the winner and `irq_out` equals the valid flag.
- R8: Once a line is latched, the status word and `irq_out` do not change until the agreement write. This holds even if the line drops, a lower-numbered line rises, or the masks change.
- R9: Writing 1 to bit 0 of the control word (address 13) clears the latch at that edge. A new winner can be latched at the following edge. Writing 0 to that bit has no effect.
- R10: When no unmasked line is pending, the valid flag and the vector field both read 0 and `irq_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Word address for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, a combinational function of `bus_addr` |
| irq_src | input | 96 | Level-sensitive interrupt lines |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with its default parameters: three banks of 32 lines, a 7-bit vector field and a 4-bit word address. With these values the test lines can be placed on both sides of each bank seam (31/32 and 63/64) and at the top line, 95. This exposes any mistake in the bank index or the bit position. It also shows whether arbitration picks the lowest line across bank boundaries, and it lets the alias writes be checked against a mask that feeds the arbiter.

// File: rtl/irqc_pkg.sv
// Package: shared types for the banked interrupt controller.
// Assumes each bank owns four consecutive word addresses, of which three are used.
package irqc_pkg;

    // Action taken on one bank's mask register in a given cycle.
    typedef enum logic [1:0] {
        MOP_NONE = 2'd0,
        MOP_LOAD = 2'd1,
        MOP_SET  = 2'd2,
        MOP_CLR  = 2'd3
    } mask_op_e;

    // Word offsets inside one bank's four-word slot.
    localparam logic [1:0] SLOT_LOAD = 2'd0;
    localparam logic [1:0] SLOT_SET  = 2'd1;
    localparam logic [1:0] SLOT_CLR  = 2'd2;

    // Bit of the control word that acknowledges the current interrupt.
    localparam int ACK_BIT = 0;

endpackage

// File: rtl/irqc_mask_bank.sv
// Module: one bank of mask bits.
// Holds W mask bits, where 1 means the line is disabled. The bits can be
// loaded in full, set where the data is 1, or cleared where the data is 1.
// Assumes at most one operation per cycle, decoded by the parent.
module irqc_mask_bank
    import irqc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  mask_op_e     op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);

    // Mask register update: resets to all disabled, then applies the op.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else begin
            case (op)
                MOP_LOAD: mask_q <= wdata;
                MOP_SET:  mask_q <= mask_q | wdata;
                MOP_CLR:  mask_q <= mask_q & ~wdata;
                default:  mask_q <= mask_q;
            endcase
        end
    end

endmodule

// File: rtl/irqc_arbiter.sv
// Module: fixed-priority arbiter.
// Finds the lowest-numbered asserted request and reports whether any request
// is asserted. Purely combinational. Assumes N fits in VEC_W bits.
module irqc_arbiter #(
    parameter int N     = 96,
    parameter int VEC_W = 7
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [VEC_W-1:0] idx
);

    // Priority search: scanning from the top down leaves the lowest index last.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = VEC_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqc_vec_hold.sv
// Module: vector latch and handshake.
// When idle, captures the arbiter winner and raises held. Keeps the vector
// frozen until ack, then clears itself so a new winner can be taken on the
// next edge. Assumes ack is a single-cycle pulse.
module irqc_vec_hold #(
    parameter int VEC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any,
    input  logic [VEC_W-1:0] idx,
    input  logic             ack,
    output logic             held,
    output logic [VEC_W-1:0] vec
);

    // Latch state: capture when idle, release only on the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
            vec  <= '0;
        end else if (held) begin
            if (ack) begin
                held <= 1'b0;
                vec  <= '0;
            end
        end else if (any) begin
            held <= 1'b1;
            vec  <= idx;
        end
    end

endmodule

// File: rtl/banked_irq_ctrl.sv
// Module: banked maskable interrupt controller (top).
// NUM_BANKS banks of BANK_W level-sensitive lines, each bank with a mask
// register and set/clear aliases, a lowest-index arbiter, and a vector latch
// released by writing the acknowledge bit. Register map: bank b at words
// 4b..4b+2, status at word 4*NUM_BANKS, control at the next word.
// Assumes the bus reads combinationally and writes take effect at the edge.
module banked_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int VEC_W     = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [BANK_W-1:0]           bus_wdata,
    output logic [BANK_W-1:0]           bus_rdata,
    input  logic [NUM_BANKS*BANK_W-1:0] irq_src,
    output logic                        irq_out
);

    localparam int NUM_SRC   = NUM_BANKS * BANK_W;
    localparam int BSEL_W    = ADDR_W - 2;
    localparam int STAT_WORD = NUM_BANKS * 4;
    localparam int CTRL_WORD = STAT_WORD + 1;

    logic [NUM_SRC-1:0] mask_flat;
    logic [NUM_SRC-1:0] pending;
    logic               win_any;
    logic [VEC_W-1:0]   win_idx;
    logic               held;
    logic [VEC_W-1:0]   vec_q;
    logic               ack_pulse;
    logic [BSEL_W-1:0]  bank_sel;
    logic [1:0]         slot_sel;

    assign bank_sel = bus_addr[ADDR_W-1:2];
    assign slot_sel = bus_addr[1:0];

    // One mask bank per group of BANK_W lines, each with its own write decode.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        mask_op_e op;

        // Bank write decode: which action, if any, this bank takes this cycle.
        always_comb begin
            op = MOP_NONE;
            if (bus_we && bank_sel == BSEL_W'(b)) begin
                case (slot_sel)
                    SLOT_LOAD: op = MOP_LOAD;
                    SLOT_SET:  op = MOP_SET;
                    SLOT_CLR:  op = MOP_CLR;
                    default:   op = MOP_NONE;
                endcase
            end
        end

        irqc_mask_bank #(.W(BANK_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .op     (op),
            .wdata  (bus_wdata),
            .mask_q (mask_flat[b*BANK_W +: BANK_W])
        );
    end

    assign pending = irq_src & ~mask_flat;

    irqc_arbiter #(.N(NUM_SRC), .VEC_W(VEC_W)) u_arb (
        .req (pending),
        .any (win_any),
        .idx (win_idx)
    );

    assign ack_pulse = bus_we && (bus_addr == ADDR_W'(CTRL_WORD)) && bus_wdata[ACK_BIT];

    irqc_vec_hold #(.VEC_W(VEC_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .any   (win_any),
        .idx   (win_idx),
        .ack   (ack_pulse),
        .held  (held),
        .vec   (vec_q)
    );

    assign irq_out = held;

    // Read mux: status word, the control word (reads 0), or a bank mask.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(STAT_WORD)) begin
            bus_rdata[VEC_W-1:0] = vec_q;
            bus_rdata[VEC_W]     = held;
        end else if (bus_addr != ADDR_W'(CTRL_WORD) && slot_sel != 2'd3) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bank_sel == BSEL_W'(b)) begin
                    bus_rdata = mask_flat[b*BANK_W +: BANK_W];
                end
            end
        end
    end

endmodule

// File: rtl/irqc_checker.sv
// Module: assertion checker for banked_irq_ctrl, attached through bind.
// Watches the bus, the lines, the mask vector and the latch, and checks the
// handshake and alias rules over time.
module irqc_checker #(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int VEC_W     = 7
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_we,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [BANK_W-1:0]           bus_wdata,
    input logic [NUM_BANKS*BANK_W-1:0] irq_src,
    input logic                        irq_out,
    input logic [NUM_BANKS*BANK_W-1:0] mask_flat,
    input logic [VEC_W-1:0]            vec_q,
    input logic                        ack
);

    localparam int NUM_SRC = NUM_BANKS * BANK_W;

    logic [NUM_SRC-1:0] pend_now;
    logic [NUM_SRC-1:0] pend_q;

    assign pend_now = irq_src & ~mask_flat;

    // Pending vector of the previous cycle, for the winner check.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_now;
    end

    AST_LATCH_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out && |pend_now) |=> irq_out);                              // R7
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !ack) |=> (irq_out && $stable(vec_q)));                // R8
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && ack) |=> !irq_out);                                    // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out && !(|pend_now)) |=> !irq_out);                          // R10
    AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> pend_q[vec_q]);                                 // R6
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (int'(vec_q) < NUM_SRC));                              // R5

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_alias
        AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == ADDR_W'(b*4 + 1)) |=>
            ((mask_flat[b*BANK_W +: BANK_W] & $past(bus_wdata)) == $past(bus_wdata))); // R3
        AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == ADDR_W'(b*4 + 2)) |=>
            ((mask_flat[b*BANK_W +: BANK_W] & $past(bus_wdata)) == '0));   // R4
    end

endmodule

bind banked_irq_ctrl irqc_checker #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .ADDR_W    (ADDR_W),
    .VEC_W     (VEC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_src   (irq_src),
    .irq_out   (irq_out),
    .mask_flat (mask_flat),
    .vec_q     (vec_q),
    .ack       (ack_pulse)
);

// File: tb/banked_irq_ctrl_test.sv
// Bench: table-driven arbitration checks followed by directed tests.
module banked_irq_ctrl_test;

    localparam int NSRC = 96;
    localparam logic [3:0] A_STAT = 4'd12;
    localparam logic [3:0] A_CTRL = 4'd13;

    // Entry: {lines, expected valid, expected vector}, checked with all masks open.
    localparam int NT = 8;
    localparam logic [NSRC+7:0] TBL [NT] = '{
        {(96'd1 << 5),                   1'b1, 7'd5},
        {(96'd1 << 40) | (96'd1 << 70),  1'b1, 7'd40},
        {(96'd1 << 95),                  1'b1, 7'd95},
        {(96'd1 << 32) | (96'd1 << 31),  1'b1, 7'd31},
        {(96'd1 << 64),                  1'b1, 7'd64},
        {(96'd1 << 0) | (96'd1 << 95),   1'b1, 7'd0},
        {96'd0,                          1'b0, 7'd0},
        {(96'd1 << 63) | (96'd1 << 64),  1'b1, 7'd63}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_we = 1'b0;
    logic [3:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NSRC-1:0] irq_src = '0;
    logic            irq_out;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    banked_irq_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_src   (irq_src),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R1: watchdog actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq after reset", 32'(irq_out), 32'd0);
        for (int b = 0; b < 3; b++) begin
            bus_read(4'(b * 4), rd);
            check("R1 mask after reset", rd, 32'hFFFF_FFFF);
        end
        bus_read(A_STAT, rd);
        check("R1 status after reset", rd, 32'd0);

        // R5: all lines masked, none may raise the request
        irq_src = '1;
        repeat (3) @(negedge clk);
        check("R5 masked lines quiet", 32'(irq_out), 32'd0);
        irq_src = '0;

        // R2: full load and readback
        bus_write(4'd4, 32'hA5A5_0F0F);
        bus_read(4'd4, rd);
        check("R2 bank1 load readback", rd, 32'hA5A5_0F0F);
        for (int b = 0; b < 3; b++) bus_write(4'(b * 4), 32'd0);

        // R6 R7 R10: table of line patterns
        for (int t = 0; t < NT; t++) begin
            @(negedge clk);
            irq_src = TBL[t][NSRC+7:8];
            @(negedge clk);
            bus_read(A_STAT, rd);
            check("R6/R7 status vector", rd, {24'd0, TBL[t][7], TBL[t][6:0]});
            check("R7 irq equals valid", 32'(irq_out), 32'(TBL[t][7]));
            irq_src = '0;
            bus_write(A_CTRL, 32'd1);
        end

        // R3: set alias touches only the 1 bits
        bus_write(4'd9, 32'h0000_0011);
        bus_read(4'd8, rd);
        check("R3 set alias first", rd, 32'h0000_0011);
        bus_write(4'd9, 32'h0000_0100);
        bus_read(4'd8, rd);
        check("R3 set alias keeps zeros", rd, 32'h0000_0111);

        // R4: clear alias touches only the 1 bits
        bus_write(4'd10, 32'h0000_0010);
        bus_read(4'd8, rd);
        check("R4 clear alias", rd, 32'h0000_0101);

        // R5: line 64 is bank 2 bit 0, masked now
        irq_src = (96'd1 << 64);
        repeat (2) @(negedge clk);
        check("R5 line 64 masked by bank2 bit0", 32'(irq_out), 32'd0);
        irq_src = '0;
        bus_write(4'd8, 32'd0);

        // R8: latched vector stays frozen
        irq_src = (96'd1 << 10);
        @(negedge clk);
        irq_src = (96'd1 << 3);
        repeat (3) @(negedge clk);
        bus_read(A_STAT, rd);
        check("R8 frozen after line change", rd, 32'h0000_008A);
        bus_write(4'd1, 32'hFFFF_FFFF);
        bus_read(A_STAT, rd);
        check("R8 frozen after mask write", rd, 32'h0000_008A);
        check("R8 irq held", 32'(irq_out), 32'd1);
        bus_write(4'd0, 32'd0);

        // R9: writing 0 to the ack bit does nothing
        bus_write(A_CTRL, 32'd0);
        bus_read(A_STAT, rd);
        check("R9 zero ack ignored", rd, 32'h0000_008A);

        // R9: ack releases, next edge takes line 3
        bus_write(A_CTRL, 32'd1);
        check("R9 irq released", 32'(irq_out), 32'd0);
        bus_read(A_STAT, rd);
        check("R9 status cleared", rd, 32'd0);
        @(negedge clk);
        bus_read(A_STAT, rd);
        check("R9 re-arbitration", rd, 32'h0000_0083);

        // R2: all banks loaded with ones disable every line
        irq_src = '1;
        for (int b = 0; b < 3; b++) bus_write(4'(b * 4), 32'hFFFF_FFFF);
        bus_write(A_CTRL, 32'd1);
        repeat (2) @(negedge clk);
        check("R2 all masked quiet", 32'(irq_out), 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule